// File: doc/BRIEF.md
# Submission Queue Doorbell Fetch Engine

This block is the device-side front end of a single command submission ring. The host places 64-byte command records into a circular array in its own memory. It then announces them by writing a new producer index to a doorbell. The engine keeps that producer index (the tail) next to its own consumer index (the head). From the two it derives how many records are waiting, and it pulls them from host memory one record at a time, in slot order, starting at the head.

Each record is fetched through a plain request/response memory port. The returned record is held and offered downstream on a valid/ready stream, tagged with the slot it came from. The head moves on by one only once downstream has taken the record. The head is also driven out of the block, so that the completion path can report how far the ring has been consumed. A doorbell value that names a slot outside the ring is refused. It leaves the tail unchanged and sets an error flag that stays set until reset.

Top module: `sq_fetch_engine`

## Requirements
- R1: After reset the head and the tail are 0, `pend_cnt` is 0, `db_err` is 0 and no memory request is issued.
- R2: A doorbell write whose value is below DEPTH loads the tail. From the next cycle `pend_cnt` equals (tail - head) modulo DEPTH.
- R3: A doorbell write whose value is DEPTH or more leaves the tail unchanged and sets `db_err`. `db_err` then stays 1 until reset.
- R4: A fetch request for slot s carries `req_addr` = SQ_BASE + 64*s. Slots are requested in ring order starting at the head.
- R5: Only one fetch is outstanding at a time. No request is raised from the request handshake until the downstream handshake of that record.
- R6: The downstream record carries `out_slot` equal to the fetched slot and `out_data` equal to the response data captured for it.
- R7: The head advances by exactly one on each downstream handshake and at no other time. After DEPTH-1 it wraps to 0.
- R8: One doorbell write that makes several records pending leads to all of them being fetched without any further doorbell write.
- R9: While `req_valid` is 1 and `req_ready` is 0, `req_valid` stays 1 and `req_addr` stays unchanged.
- R10: While head equals tail, no fetch request is issued.
- R11: A doorbell write in the same cycle as a downstream handshake has both effects: the tail is loaded and the head advances.

Note: R1–R3 and R7 assume the default DEPTH of 8 in the bench.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| db_wr | input | 1 | Doorbell write strobe |
| db_value | input | DB_W | New tail index written by the host |
| req_valid | output | 1 | Memory read request valid |
| req_ready | input | 1 | Memory read request accepted |
| req_addr | output | ADDR_W | Byte address of the requested record |
| rsp_valid | input | 1 | Memory read response valid |
| rsp_data | input | 512 | 64-byte record returned by memory |
| out_valid | output | 1 | Fetched record valid downstream |
| out_ready | input | 1 | Downstream accepts the record |
| out_data | output | 512 | Fetched record |
| out_slot | output | IDX_W | Ring slot of the fetched record |
| head_o | output | IDX_W | Current head for completion reporting |
| pend_cnt | output | IDX_W | Records announced but not yet consumed |
| db_err | output | 1 | Sticky flag for an out-of-range doorbell |

## Verification
A doorbell write and the head advance can fall in the same clock cycle. The tail register and the head register are then both updated, and the pending count must combine the two. The bench provokes this by raising `db_wr` with a fresh tail value on the very cycle it raises `out_ready` for a waiting record. One cycle later it judges `head_o` against the old head plus one and `pend_cnt` against the new tail minus that advanced head, modulo the ring size. A second case lands an out-of-range doorbell while a fetch is stalled. The fetch must then go on from the unchanged slot and the error must stick.

// File: rtl/sqf_pkg.sv
package sqf_pkg;
  localparam int ENTRY_BYTES = 64;
  localparam int ENTRY_BITS  = ENTRY_BYTES * 8;
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2,
    FS_OUT  = 2'd3
  } fetch_state_e;
endpackage

// File: rtl/sqf_tail_reg.sv
module sqf_tail_reg #(
  parameter int DEPTH = 8,
  parameter int DB_W  = 16,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             db_wr,
  input  logic [DB_W-1:0]  db_value,
  output logic [IDX_W-1:0] tail,
  output logic             err
);
  logic             in_range;
  logic             tail_en;
  logic             err_en;
  logic [IDX_W-1:0] tail_d;

  always_comb begin
    in_range = (32'(db_value) < 32'(DEPTH));
    tail_en  = db_wr && in_range;
    err_en   = db_wr && !in_range;
    tail_d   = db_value[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail <= '0;
    end else if (tail_en) begin
      tail <= tail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err <= 1'b0;
    end else if (err_en) begin
      err <= 1'b1;
    end
  end
endmodule

// File: rtl/sqf_head_reg.sv
module sqf_head_reg #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] pend
);
  localparam bit POW2 = (DEPTH == (1 << IDX_W));

  logic [IDX_W-1:0] head_d;

  generate
    if (POW2) begin : g_pow2
      always_comb begin
        head_d = head + 1'b1;
        pend   = tail - head;
      end
    end else begin : g_any
      logic [IDX_W:0] span;
      always_comb begin
        head_d = (head == IDX_W'(DEPTH - 1)) ? '0 : head + 1'b1;
        if (tail >= head) span = {1'b0, tail} - {1'b0, head};
        else              span = (IDX_W+1)'(DEPTH) + {1'b0, tail} - {1'b0, head};
        pend = span[IDX_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
    end else if (advance) begin
      head <= head_d;
    end
  end
endmodule

// File: rtl/sqf_fetch_ctl.sv
module sqf_fetch_ctl
  import sqf_pkg::*;
#(
  parameter int              IDX_W   = 3,
  parameter int              ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] SQ_BASE = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  have_work,
  input  logic [IDX_W-1:0]      head,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [ADDR_W-1:0]     req_addr,
  input  logic                  rsp_valid,
  input  logic [ENTRY_BITS-1:0] rsp_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [ENTRY_BITS-1:0] out_data,
  output logic [IDX_W-1:0]      out_slot,
  output logic                  advance
);
  fetch_state_e state_q, state_d;
  logic         capture;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FS_IDLE: if (have_work) state_d = FS_REQ;
      FS_REQ:  if (req_ready) state_d = FS_WAIT;
      FS_WAIT: if (rsp_valid) state_d = FS_OUT;
      FS_OUT:  if (out_ready) state_d = FS_IDLE;
      default: state_d = FS_IDLE;
    endcase
  end

  always_comb begin
    req_valid = (state_q == FS_REQ);
    out_valid = (state_q == FS_OUT);
    capture   = (state_q == FS_WAIT) && rsp_valid;
    advance   = out_valid && out_ready;
    req_addr  = SQ_BASE + (ADDR_W'(head) << ENTRY_SHIFT);
    out_slot  = head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (capture) begin
      out_data <= rsp_data;
    end
  end
endmodule

// File: rtl/sq_fetch_engine.sv
module sq_fetch_engine
  import sqf_pkg::*;
#(
  parameter int                DEPTH   = 8,
  parameter int                DB_W    = 16,
  parameter int                ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] SQ_BASE = 32'h0000_1000,
  localparam int               IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  db_wr,
  input  logic [DB_W-1:0]       db_value,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [ADDR_W-1:0]     req_addr,
  input  logic                  rsp_valid,
  input  logic [ENTRY_BITS-1:0] rsp_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [ENTRY_BITS-1:0] out_data,
  output logic [IDX_W-1:0]      out_slot,
  output logic [IDX_W-1:0]      head_o,
  output logic [IDX_W-1:0]      pend_cnt,
  output logic                  db_err
);
  logic [IDX_W-1:0] tail;
  logic             advance;
  logic             have_work;

  assign have_work = (pend_cnt != '0);

  sqf_tail_reg #(.DEPTH(DEPTH), .DB_W(DB_W), .IDX_W(IDX_W)) i_tail (
    .clk      (clk),
    .rst_n    (rst_n),
    .db_wr    (db_wr),
    .db_value (db_value),
    .tail     (tail),
    .err      (db_err)
  );

  sqf_head_reg #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_head (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .tail    (tail),
    .head    (head_o),
    .pend    (pend_cnt)
  );

  sqf_fetch_ctl #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .SQ_BASE(SQ_BASE)) i_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .have_work (have_work),
    .head      (head_o),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_slot  (out_slot),
    .advance   (advance)
  );
endmodule

// File: rtl/sq_fetch_engine_chk.sv
module sq_fetch_engine_chk #(
  parameter int DEPTH  = 8,
  parameter int DB_W   = 16,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              db_wr,
  input logic [DB_W-1:0]   db_value,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [IDX_W-1:0]  out_slot,
  input logic [IDX_W-1:0]  head_o,
  input logic [IDX_W-1:0]  pend_cnt,
  input logic              db_err
);
  // R3: an out-of-range doorbell raises the error flag
  p_bad_db_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (db_wr && (32'(db_value) >= 32'(DEPTH))) |=> db_err);

  // R3: the error flag is sticky
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    db_err |=> db_err);

  // R5: a pending record blocks any new request
  p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> !req_valid);

  // R6: the record tag names the current head
  p_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_slot == head_o));

  // R7: one step per handshake, with wrap
  p_head_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=>
      (head_o == (($past(head_o) == IDX_W'(DEPTH - 1)) ? '0 : $past(head_o) + 1'b1)));

  // R7: no movement without a handshake
  p_head_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_ready) |=> $stable(head_o));

  // R9: request held steady under back-pressure
  p_req_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R10: a request only starts when work was pending
  p_empty_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> ($past(pend_cnt) != '0));
endmodule

bind sq_fetch_engine sq_fetch_engine_chk #(
  .DEPTH(DEPTH), .DB_W(DB_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) i_chk (.*);

// File: tb/test_sq_fetch_engine.sv
module test_sq_fetch_engine;
  localparam int          DEPTH = 8;
  localparam int          DB_W  = 16;
  localparam int          AW    = 32;
  localparam logic [31:0] BASE  = 32'h0000_1000;
  localparam int          IW    = 3;

  logic           clk;
  logic           rst_n;
  logic           db_wr;
  logic [DB_W-1:0] db_value;
  logic           req_valid, req_ready;
  logic [AW-1:0]  req_addr;
  logic           rsp_valid;
  logic [511:0]   rsp_data;
  logic           out_valid, out_ready;
  logic [511:0]   out_data;
  logic [IW-1:0]  out_slot, head_o, pend_cnt;
  logic           db_err;

  int checks = 0;
  int errors = 0;
  int model_head = 0;
  int nfetch = 0;

  sq_fetch_engine #(.DEPTH(DEPTH), .DB_W(DB_W), .ADDR_W(AW), .SQ_BASE(BASE)) i_sq_fetch_engine (
    .clk(clk), .rst_n(rst_n), .db_wr(db_wr), .db_value(db_value),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_slot(out_slot), .head_o(head_o), .pend_cnt(pend_cnt), .db_err(db_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // stimulus rows: doorbell value, expected err, expected pending, records to fetch
  typedef struct packed {
    logic [15:0] dbv;
    logic        err;
    logic [3:0]  pend;
    logic [3:0]  nf;
  } row_t;
  localparam int NROWS = 5;
  localparam row_t ROWS [NROWS] = '{
    '{16'd3, 1'b0, 4'd3, 4'd3},
    '{16'd7, 1'b0, 4'd4, 4'd4},
    '{16'd2, 1'b0, 4'd3, 4'd0},
    '{16'd8, 1'b1, 4'd3, 4'd3},
    '{16'd5, 1'b1, 4'd3, 4'd3}
  };

  function automatic logic [511:0] pat(int k);
    return {16{32'hA500_0000 ^ 32'(k)}};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doorbell(input int v);
    db_wr = 1'b1; db_value = DB_W'(v);
    @(negedge clk);
    db_wr = 1'b0;
  endtask

  // one record: optional request stall, optional doorbell on the output handshake
  task automatic fetch_one(input int stall, input bit with_db, input int dbv);
    int s;
    s = model_head;
    while (!req_valid) @(negedge clk);
    chk(req_addr == BASE + 32'(s * 64), "R4", "request address", req_addr, BASE + 32'(s * 64));
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(req_valid && req_addr == BASE + 32'(s * 64), "R9", "held request", req_addr, BASE + 32'(s * 64));
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk(!req_valid, "R5", "no second request", req_valid, 0);
    rsp_valid = 1'b1; rsp_data = pat(nfetch);
    @(negedge clk);
    rsp_valid = 1'b0; rsp_data = '0;
    chk(out_valid && out_slot == IW'(s), "R6", "slot tag", out_slot, s);
    chk(out_data == pat(nfetch), "R6", "record data", out_data[31:0], pat(nfetch) & 32'hFFFF_FFFF);
    chk(head_o == IW'(s), "R7", "head before handshake", head_o, s);
    out_ready = 1'b1;
    if (with_db) begin db_wr = 1'b1; db_value = DB_W'(dbv); end
    @(negedge clk);
    out_ready = 1'b0; db_wr = 1'b0;
    model_head = (model_head + 1) % DEPTH;
    nfetch++;
    chk(head_o == IW'(model_head), "R7", "head after handshake", head_o, model_head);
  endtask

  initial begin
    #(5ns * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; db_wr = 1'b0; db_value = '0; req_ready = 1'b0;
    rsp_valid = 1'b0; rsp_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(head_o == 0 && pend_cnt == 0, "R1", "head/pending after reset", {head_o, pend_cnt}, 0);
    chk(!db_err && !req_valid, "R1", "err/request after reset", {db_err, req_valid}, 0);

    // vector walk: R2, R3, R4, R7 wrap, R8
    for (int r = 0; r < NROWS; r++) begin
      doorbell(int'(ROWS[r].dbv));
      chk(db_err == ROWS[r].err, "R3", "error flag", db_err, ROWS[r].err);
      chk(pend_cnt == IW'(ROWS[r].pend), "R2", "pending count", pend_cnt, ROWS[r].pend);
      for (int f = 0; f < int'(ROWS[r].nf); f++) fetch_one(0, 1'b0, 0);
      if (ROWS[r].nf != 0)
        chk(pend_cnt == 0, "R8", "all records drained", pend_cnt, 0);
    end

    // R10: empty ring, no request
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!req_valid, "R10", "idle when empty", req_valid, 0);
    end

    // R11: doorbell lands on the output handshake (head 5 -> 6, tail 7 -> 1)
    doorbell(7);
    chk(pend_cnt == 2, "R2", "pending before overlap", pend_cnt, 2);
    fetch_one(0, 1'b1, 1);
    chk(pend_cnt == 3, "R11", "pending after overlap", pend_cnt, 3);
    // R9 stall, then the rest wraps to slot 0
    fetch_one(3, 1'b0, 0);
    fetch_one(0, 1'b0, 0);
    fetch_one(0, 1'b0, 0);
    chk(head_o == 1 && pend_cnt == 0, "R7", "wrapped head", head_o, 1);

    // R3 bad doorbell while pending, tail kept
    doorbell(4);
    doorbell(15);
    chk(pend_cnt == 3 && db_err, "R3", "tail kept on bad value", pend_cnt, 3);
    fetch_one(0, 1'b0, 0);
    fetch_one(0, 1'b0, 0);
    fetch_one(0, 1'b0, 0);

    // R1: reset clears the sticky error
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_head = 0;
    @(negedge clk);
    chk(!db_err && head_o == 0 && pend_cnt == 0, "R1", "state after second reset", {db_err, head_o, pend_cnt}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule